// File: doc/BRIEF.md
# UART Channel-Mode FIFO Router

This block sits between the serial engine of a UART and its register file. It holds one receive byte queue and one transmit byte queue, 16 entries each by default. It moves each byte to the right queue according to a two-bit channel mode taken from the mode word. In normal mode, serial bytes fill the receive queue and data-register writes fill the transmit queue. Automatic echo sends every serial byte to both queues. Local loopback turns data-register writes back into the receive queue. Remote loopback turns serial bytes straight round into the transmit queue.

The control word carries a flush bit, an enable bit and a disable bit for each direction. Each flush bit empties its queue and clears itself on the same edge. The control word leaves reset with both directions disabled. A byte that finds its queue full is discarded, and the block reports it on a one-cycle overrun pin for that direction. The serial source is told how many bytes it may still send through `ser_room`. It should not present a byte while `ser_room` is zero; a byte it presents anyway is handled as an overrun. The transmit output is a valid/ready stream. `tx_valid` is high whenever the transmit queue holds a byte, and the byte is consumed on any cycle where `tx_ready` is also high. The data register read is a plain strobe with a combinational return value.

Top module: `uart_chan_router`

## Requirements
- R1: The channel mode is mode_word bits 9:8, with 0 normal, 1 echo, 2 local loopback and 3 remote loopback. A serial byte (ser_valid) is queued for receive in modes 0 and 1, and for transmit in modes 1 and 3.
- R2: A data-register write (dr_wr_valid) is queued for transmit in mode 0 and for receive in mode 2. In modes 1 and 3 it changes neither queue.
- R3: ser_room equals DEPTH. In modes 0 and 1 it is reduced to no more than the free receive entries. In modes 1 and 3 it is reduced to no more than the free transmit entries.
- R4: A control write with bit 0 set empties the receive queue, and one with bit 1 set empties the transmit queue. A flush wins over a push or pop in the same cycle. Both bits read back as zero afterwards.
- R5: The receive direction acts only while control bit 2 is 1 and bit 3 is 0. Otherwise pushes into it and reads from it are ignored.
- R6: The transmit direction accepts pushes only while control bit 4 is 1 and bit 5 is 0.
- R7: A push into a full receive queue discards the byte and pulses rx_overrun in that cycle. A push into a full transmit queue discards the byte and pulses tx_overrun. Fullness is judged from the level at the start of the cycle.
- R8: dr_rd_data is 0 when the receive queue is empty or the receive direction is off. A read strobe in that state removes nothing.
- R9: ser_break counts as one serial byte of value 0. It goes to the receive queue in modes 0 and 1, never to the transmit queue, and it overrides ser_valid.
- R10: The control word resets to 0x128.
- R11: tx_valid is high exactly while the transmit queue is non-empty. Each cycle with tx_valid and tx_ready removes the oldest byte, which is shown on tx_data.
- R12: The receive queue returns bytes oldest first on dr_rd_data. One is removed per enabled read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_word | input | 10 | mode word; bits 9:8 select the channel mode |
| ctrl_we | input | 1 | control word write strobe |
| ctrl_wdata | input | 9 | control word write value |
| ctrl_q | output | 9 | current control word |
| dr_wr_valid | input | 1 | data register write strobe |
| dr_wr_data | input | 8 | data register write byte |
| dr_rd_en | input | 1 | data register read strobe (pops receive queue) |
| dr_rd_data | output | 8 | byte at the head of the receive queue, or 0 |
| ser_valid | input | 1 | serial side delivers a byte |
| ser_data | input | 8 | serial byte |
| ser_break | input | 1 | serial side saw a line break |
| ser_room | output | 5 | bytes the serial side may still deliver |
| tx_valid | output | 1 | transmit byte available |
| tx_data | output | 8 | oldest transmit byte |
| tx_ready | input | 1 | serial side takes the transmit byte |
| rx_overrun | output | 1 | receive push discarded this cycle |
| tx_overrun | output | 1 | transmit push discarded this cycle |
| rx_level | output | 5 | receive queue occupancy |
| tx_level | output | 5 | transmit queue occupancy |

## Verification
The bench fills each queue to exactly 16 and then pushes one more. A router that judged fullness after a same-cycle pop would accept that byte, and one with an off-by-one limit would raise overrun one byte early. Echo mode is driven with unequal occupancies, so a `ser_room` that ignored one of the two queues would report too much room. Flushes are issued while bytes are arriving, which catches a push that beats the flush. Break, disable-while-enabled and empty reads are each driven on their own, so a design that let a break into the transmit queue, treated bit 3 as don't-care, or popped on an empty read would show a level or data mismatch.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;
  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_ON    = 2;
  localparam int CB_RX_OFF   = 3;
  localparam int CB_TX_ON    = 4;
  localparam int CB_TX_OFF   = 5;
  localparam int MODE_LSB    = 8;
endpackage

// File: rtl/uart_rt_ctrl.sv
module uart_rt_ctrl #(
  parameter int CTRL_W = 9,
  parameter logic [CTRL_W-1:0] CTRL_RST = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              rx_en,
  output logic              tx_en
);
  import uart_rt_pkg::*;

  localparam logic [CTRL_W-1:0] SELF_CLR = CTRL_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTRL_RST;
    else if (we) q <= wdata & ~SELF_CLR;
  end

  assign rx_flush = we & wdata[CB_RX_FLUSH];
  assign tx_flush = we & wdata[CB_TX_FLUSH];
  assign rx_en    = q[CB_RX_ON] & ~q[CB_RX_OFF];
  assign tx_en    = q[CB_TX_ON] & ~q[CB_TX_OFF];

  // R4: flush bits never persist after a write
  p_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q[1:0] == 2'b00));
endmodule

// File: rtl/uart_rt_fifo.sv
module uart_rt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R7: occupancy never exceeds the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7: a push on a full queue without a pop leaves it full
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  // R4: a flush empties the queue on the next cycle
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int CTRL_W = 9,
  parameter int MODE_W = 10,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              dr_wr_valid,
  input  logic [DW-1:0]     dr_wr_data,
  input  logic              dr_rd_en,
  output logic [DW-1:0]     dr_rd_data,
  input  logic              ser_valid,
  input  logic [DW-1:0]     ser_data,
  input  logic              ser_break,
  output logic [CW-1:0]     ser_room,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready,
  output logic              rx_overrun,
  output logic              tx_overrun,
  output logic [CW-1:0]     rx_level,
  output logic [CW-1:0]     tx_level
);
  import uart_rt_pkg::*;

  chan_mode_e mode;
  logic rx_flush, tx_flush, rx_en, tx_en;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic [DW-1:0] rx_head;
  logic ser_in, rx_req, tx_req;
  logic [DW-1:0] ser_byte, rx_byte, tx_byte;
  logic to_rx_ser, to_tx_ser;

  assign mode = chan_mode_e'(mode_word[MODE_LSB+1:MODE_LSB]);

  uart_rt_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_en(rx_en), .tx_en(tx_en)
  );

  assign to_rx_ser = (mode == CM_NORMAL) || (mode == CM_ECHO);
  assign to_tx_ser = (mode == CM_ECHO) || (mode == CM_REMOTE);
  assign ser_in    = ser_valid | ser_break;
  assign ser_byte  = ser_break ? '0 : ser_data;

  always_comb begin
    rx_req  = 1'b0;
    rx_byte = ser_byte;
    if (to_rx_ser && ser_in) rx_req = 1'b1;
    else if (mode == CM_LOCAL && dr_wr_valid) begin
      rx_req  = 1'b1;
      rx_byte = dr_wr_data;
    end
  end

  always_comb begin
    tx_req  = 1'b0;
    tx_byte = ser_data;
    if (to_tx_ser && ser_valid && !ser_break) tx_req = 1'b1;
    else if (mode == CM_NORMAL && dr_wr_valid) begin
      tx_req  = 1'b1;
      tx_byte = dr_wr_data;
    end
  end

  uart_rt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_req & rx_en), .push_data(rx_byte),
    .pop(dr_rd_en & rx_en), .head(rx_head),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  uart_rt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_req & tx_en), .push_data(tx_byte),
    .pop(tx_ready), .head(tx_data),
    .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

  assign dr_rd_data = (rx_en && !rx_empty) ? rx_head : '0;
  assign tx_valid   = ~tx_empty;
  assign rx_overrun = rx_req & rx_en & rx_full;
  assign tx_overrun = tx_req & tx_en & tx_full;

  always_comb begin
    ser_room = CW'(DEPTH);
    if (to_rx_ser && (CW'(DEPTH) - rx_level) < ser_room) ser_room = CW'(DEPTH) - rx_level;
    if (to_tx_ser && (CW'(DEPTH) - tx_level) < ser_room) ser_room = CW'(DEPTH) - tx_level;
  end

  // R3: room never exceeds depth
  p_room_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_room <= CW'(DEPTH));
  // R8: empty receive queue reads as zero
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> (dr_rd_data == '0));
  // R2: writes in remote loopback leave the receive queue alone
  p_drop_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr_valid && mode == CM_REMOTE && !ctrl_we && !dr_rd_en)
      |=> (rx_level == $past(rx_level)));
  // R11: a stalled transmit byte stays put
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ctrl_we) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/test_uart_chan_router.sv
module test_uart_chan_router;
  logic       clk = 0;
  logic       rst_n;
  logic [9:0] mode_word;
  logic       ctrl_we;
  logic [8:0] ctrl_wdata, ctrl_q;
  logic       dr_wr_valid, dr_rd_en, ser_valid, ser_break, tx_ready;
  logic [7:0] dr_wr_data, dr_rd_data, ser_data, tx_data;
  logic [4:0] ser_room, rx_level, tx_level;
  logic       tx_valid, rx_overrun, tx_overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  byte unsigned rxq[$], txq[$];
  int ctrl_m = 'h128;

  always #5 clk = ~clk;

  uart_chan_router i_uart_chan_router (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .dr_wr_valid(dr_wr_valid),
    .dr_wr_data(dr_wr_data), .dr_rd_en(dr_rd_en), .dr_rd_data(dr_rd_data),
    .ser_valid(ser_valid), .ser_data(ser_data), .ser_break(ser_break),
    .ser_room(ser_room), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_overrun(rx_overrun), .tx_overrun(tx_overrun),
    .rx_level(rx_level), .tx_level(tx_level)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_we = 0; ctrl_wdata = 0; dr_wr_valid = 0; dr_wr_data = 0;
    dr_rd_en = 0; ser_valid = 0; ser_data = 0; ser_break = 0; tx_ready = 0;
  endtask

  // compare at mid-cycle, then advance the model over the next edge
  task automatic step();
    int md;
    bit rxe, txe, rxa, txa, sin, rpop, rpush, tpop, tpush;
    byte unsigned rxd, txd, sd;
    int room;
    #1;
    md  = int'(mode_word[9:8]);
    rxe = ctrl_m[2] && !ctrl_m[3];
    txe = ctrl_m[4] && !ctrl_m[5];
    sin = ser_valid || ser_break;
    sd  = ser_break ? 8'h00 : ser_data;
    rxa = 0; rxd = 0; txa = 0; txd = 0;
    if ((md == 0 || md == 1) && sin) begin rxa = 1; rxd = sd; end        // R1 R9
    else if (md == 2 && dr_wr_valid) begin rxa = 1; rxd = dr_wr_data; end // R2
    if ((md == 1 || md == 3) && ser_valid && !ser_break) begin txa = 1; txd = ser_data; end
    else if (md == 0 && dr_wr_valid) begin txa = 1; txd = dr_wr_data; end
    room = 16;
    if ((md == 0 || md == 1) && 16 - rxq.size() < room) room = 16 - rxq.size();
    if ((md == 1 || md == 3) && 16 - txq.size() < room) room = 16 - txq.size();

    chk("R10 R4 ctrl_q", int'(ctrl_q), ctrl_m);
    chk("R8 R12 dr_rd_data", int'(dr_rd_data), (rxe && rxq.size() > 0) ? int'(rxq[0]) : 0);
    chk("R11 tx_valid", int'(tx_valid), int'(txq.size() > 0));
    if (txq.size() > 0) chk("R11 tx_data", int'(tx_data), int'(txq[0]));
    chk("R3 ser_room", int'(ser_room), room);
    chk("R7 rx_overrun", int'(rx_overrun), int'(rxa && rxe && rxq.size() == 16));
    chk("R7 tx_overrun", int'(tx_overrun), int'(txa && txe && txq.size() == 16));
    chk("R1 R5 rx_level", int'(rx_level), rxq.size());
    chk("R2 R6 tx_level", int'(tx_level), txq.size());

    rpop  = dr_rd_en && rxe && rxq.size() > 0;
    rpush = rxa && rxe && rxq.size() < 16;
    tpop  = tx_ready && txq.size() > 0;
    tpush = txa && txe && txq.size() < 16;
    if (rpop) void'(rxq.pop_front());
    if (rpush) rxq.push_back(rxd);
    if (tpop) void'(txq.pop_front());
    if (tpush) txq.push_back(txd);
    if (ctrl_we) begin
      ctrl_m = int'(ctrl_wdata) & 'h1FC;
      if (ctrl_wdata[0]) rxq.delete();
      if (ctrl_wdata[1]) txq.delete();
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_ctrl(int v);
    ctrl_we = 1; ctrl_wdata = 9'(v); step();
  endtask

  task automatic ser_byte(int v);
    ser_valid = 1; ser_data = 8'(v); step();
  endtask

  task automatic dr_write(int v);
    dr_wr_valid = 1; dr_wr_data = 8'(v); step();
  endtask

  task automatic dr_read();
    dr_rd_en = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_word = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(); step();                                  // R10 reset state

    // R5 R6: both paths off after reset
    ser_byte('h11); dr_write('h22); dr_read();
    wr_ctrl('h14);
    // R1 R12 R8: normal serial fill and ordered read, then empty read
    ser_byte('hA1); ser_byte('hA2); ser_byte('hA3);
    repeat (4) dr_read();
    // R7: receive overrun on the 17th byte
    for (int i = 0; i < 17; i++) ser_byte(i + 'h40);
    ser_valid = 1; ser_data = 'h99; dr_rd_en = 1; step();  // full at start: R7 discard
    repeat (16) dr_read();
    // R7 R2: transmit overrun, then R11 drain
    for (int i = 0; i < 17; i++) dr_write(i + 'h60);
    repeat (18) begin tx_ready = 1; step(); end
    // R5: bit 3 overrides enable
    wr_ctrl('h1C); ser_byte('h33); dr_read(); wr_ctrl('h14);
    // R6: bit 5 overrides enable
    wr_ctrl('h34); dr_write('h44); wr_ctrl('h14);
    // R1 R3: echo with unequal levels
    mode_word = 10'h100;
    ser_byte('h51); ser_byte('h52); dr_read(); dr_write('h53);
    repeat (3) begin tx_ready = 1; step(); end
    dr_read();
    // R2: local loopback
    mode_word = 10'h200;
    dr_write('h71); ser_byte('h72); dr_read(); dr_read();
    // R1: remote loopback
    mode_word = 10'h300;
    ser_byte('h81); dr_write('h82); ser_break = 1; step();
    tx_ready = 1; step();
    // R9: break in normal mode
    mode_word = 10'h000;
    ser_break = 1; ser_valid = 1; ser_data = 'hEE; step();
    dr_read();
    // R4: flushes win over same-cycle pushes
    ser_byte('h01); dr_write('h02); dr_write('h03);
    ser_valid = 1; ser_data = 'h04; ctrl_we = 1; ctrl_wdata = 'h17; step();
    step();

    // mixed stimulus
    for (int c = 0; c < 5000; c++) begin
      if (c % 60 == 0) mode_word = 10'($urandom_range(0, 3) << 8);
      ser_valid   = ($urandom_range(0, 2) == 0);
      ser_data    = 8'($urandom);
      ser_break   = ($urandom_range(0, 40) == 0);
      dr_wr_valid = ($urandom_range(0, 2) == 0);
      dr_wr_data  = 8'($urandom);
      dr_rd_en    = ($urandom_range(0, 3) == 0);
      tx_ready    = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 80) == 0) begin
        ctrl_we = 1;
        ctrl_wdata = ($urandom_range(0, 3) == 0) ? 9'($urandom) : 9'h014 | 9'($urandom_range(0, 3));
      end
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule